// File: doc/BRIEF.md
# Three-Phase Complementary PWM Generator

This block drives a three-phase half-bridge. Each phase has a high-side (positive) output and a low-side (negative) output. The switching edges of the two outputs in a pair are kept apart by a programmable non-overlap time, the dead time Td. Two up/down counters make a triangle carrier. The leading counter runs a fixed Td counts above the trailing one. The positive output of a phase compares its duty value against the leading counter. The negative output compares the same duty value against the trailing counter. Because the leading counter is never below the trailing one, the two outputs of a pair cannot be active together. They also switch at least Td cycles apart.

Software programs the block through a simple write port. The settings are a carrier peak value, a leading-counter peak value, three duty values, a dead-time value and six output-polarity bits. A control bit then starts the block. The two peaks and the duty values are held in buffers. On the clock that starts the block, all five buffers are copied into the active compare registers together. While the block runs, a new duty value moves into its active register only at the carrier trough. The dead time and the polarity bits are locked while the block runs.

The mode controller has two states. MODE_IDLE moves to MODE_RUN when the control register is written with bit 0 set. This is the start transition, and it loads all active registers. MODE_RUN moves back to MODE_IDLE when the control register is written with bit 0 clear. Each counter has its own direction state. DIR_UP turns to DIR_DOWN when the counter is at or above its peak. DIR_DOWN turns to DIR_UP when the counter is at or below its floor. The trailing counter's turn from DIR_DOWN to DIR_UP is the carrier trough.

Top module: `cpwm3_top`

## Requirements
- R1: After reset the block is idle, every buffer, the dead time and the active registers are zero, all six polarity bits are 1, and all outputs are 0.
- R2: Write addresses: 0 control (bit 0 = run), 1 leading peak buffer, 2 carrier peak buffer, 3/4/5 duty buffers of phases 0/1/2, 6 dead time, 7 polarity bits; buffer writes are accepted in either state.
- R3: While running, the trailing counter steps by exactly one per clock between 0 and the carrier peak H, turning at both ends, for a carrier period of 2*H clocks; the leading counter moves in lockstep between Td and its peak, so both reach their troughs together when the leading peak equals H + Td.
- R4: The clock edge that writes run = 1 while idle copies the two peaks and the three duties into the active registers, and loads the leading counter with Td and the trailing counter with 0; the outputs first show the running compare one edge later, starting from trailing count 0.
- R5: Each output is registered. A positive output is active when leading count <= duty. A negative output is active when trailing count > duty.
- R6: The two outputs of a pair are never active together. When every duty value is at least Td, any inactive gap between one output of a pair and the other becoming active lasts at least Td clocks.
- R7: While running, a duty-buffer write reaches the active register only on the edge where the trailing counter is at 0 and descending.
- R8: While running, writes to the dead time and to the polarity bits are ignored.
- R9: Polarity bit i (0..2) sets the active level of positive output i, and bit 3+i sets it for negative output i; 1 means active high, 0 means active low.
- R10: While idle, each output sits at the inverse of its polarity bit. After run is cleared, the outputs reach that level on the following edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | CW | Register write data |
| pwm_p | output | 3 | Positive-phase outputs, one per phase |
| pwm_n | output | 3 | Negative-phase outputs, one per phase |

## Verification
The bench keeps a cycle model of the carrier and compares all six outputs on every clock against it. It also measures every gap between the outputs of a pair, so a counter offset that slips or a compare that uses the wrong counter shows up as a short gap or an overlap. Duty values are rewritten during a run, so a design that transfers them mid-cycle or at the peak changes a pulse one carrier too early and breaks the waveform. The dead time and polarity are rewritten during a run and then observed after stopping, which catches a design that lets those writes through. Further corners are a duty of 0, a duty above the peak, a zero dead time, a duty below Td and mixed polarities; a missing inversion or an off-by-one compare at either end of the triangle changes the outputs there.

// File: rtl/cpwm_pkg.sv
`timescale 1ns/1ps
package cpwm_pkg;
    localparam int NPH    = 3;
    localparam int NOUT   = 2 * NPH;
    localparam int ADDR_W = 4;

    localparam logic [ADDR_W-1:0] ADDR_CTRL  = 4'd0;
    localparam logic [ADDR_W-1:0] ADDR_LIMIT = 4'd1;
    localparam logic [ADDR_W-1:0] ADDR_CYCLE = 4'd2;
    localparam logic [ADDR_W-1:0] ADDR_DUTY0 = 4'd3;
    localparam logic [ADDR_W-1:0] ADDR_DEAD  = 4'd6;
    localparam logic [ADDR_W-1:0] ADDR_LEVEL = 4'd7;

    typedef enum logic {MODE_IDLE, MODE_RUN} mode_e;
    typedef enum logic {DIR_UP, DIR_DOWN} dir_e;
endpackage

// File: rtl/cpwm_regs.sv
`timescale 1ns/1ps
module cpwm_regs
    import cpwm_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [ADDR_W-1:0]        wr_addr,
    input  logic [CW-1:0]            wr_data,
    input  logic                     trough,
    output logic                     run,
    output logic [CW-1:0]            dead_q,
    output logic [NOUT-1:0]          level_q,
    output logic [CW-1:0]            lim_act,
    output logic [CW-1:0]            cyc_act,
    output logic [NPH-1:0][CW-1:0]   duty_act
);
    mode_e                   mode_q, mode_d;
    logic                    ctrl_wr;
    logic                    start;
    logic [CW-1:0]           lim_buf, cyc_buf;
    logic [NPH-1:0][CW-1:0]  duty_buf;

    assign ctrl_wr = wr_en && (wr_addr == ADDR_CTRL);

    always_comb begin
        mode_d = mode_q;
        unique case (mode_q)
            MODE_IDLE: if (ctrl_wr && wr_data[0])  mode_d = MODE_RUN;
            MODE_RUN:  if (ctrl_wr && !wr_data[0]) mode_d = MODE_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= MODE_IDLE;
        else        mode_q <= mode_d;
    end

    always_comb begin
        run   = (mode_q == MODE_RUN);
        start = (mode_q == MODE_IDLE) && (mode_d == MODE_RUN);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lim_buf  <= '0;
            cyc_buf  <= '0;
            duty_buf <= '0;
            dead_q   <= '0;
            level_q  <= '1;
        end else if (wr_en) begin
            case (wr_addr)
                ADDR_LIMIT: lim_buf <= wr_data;
                ADDR_CYCLE: cyc_buf <= wr_data;
                ADDR_DEAD:  if (mode_q == MODE_IDLE) dead_q <= wr_data;
                ADDR_LEVEL: if (mode_q == MODE_IDLE) level_q <= wr_data[NOUT-1:0];
                default: ;
            endcase
            for (int i = 0; i < NPH; i++) begin
                if (wr_addr == ADDR_W'(int'(ADDR_DUTY0) + i)) duty_buf[i] <= wr_data;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lim_act  <= '0;
            cyc_act  <= '0;
            duty_act <= '0;
        end else if (start) begin
            lim_act  <= lim_buf;
            cyc_act  <= cyc_buf;
            duty_act <= duty_buf;
        end else if (run && trough) begin
            duty_act <= duty_buf;
        end
    end

    // R8
    dead_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run && $past(run) |-> $stable(dead_q));

    // R8
    level_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run && $past(run) |-> $stable(level_q));

    // R7
    duty_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run && $past(run) && !$past(trough) |-> $stable(duty_act));
endmodule

// File: rtl/cpwm_tri_cnt.sv
`timescale 1ns/1ps
module cpwm_tri_cnt
    import cpwm_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic [CW-1:0] lo,
    input  logic [CW-1:0] hi,
    output logic [CW-1:0] cnt,
    output logic          at_trough
);
    dir_e dir_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt   <= '0;
            dir_q <= DIR_UP;
        end else if (!run) begin
            cnt   <= lo;
            dir_q <= DIR_UP;
        end else begin
            unique case (dir_q)
                DIR_UP: begin
                    if (cnt >= hi) begin
                        cnt   <= cnt - 1'b1;
                        dir_q <= DIR_DOWN;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                DIR_DOWN: begin
                    if (cnt <= lo) begin
                        cnt   <= cnt + 1'b1;
                        dir_q <= DIR_UP;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
            endcase
        end
    end

    assign at_trough = run && (dir_q == DIR_DOWN) && (cnt <= lo);

    // R3
    unit_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run && $past(run) |-> (cnt == CW'($past(cnt) + 1'b1)) || (cnt == CW'($past(cnt) - 1'b1)));

    // R3
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run && (hi > lo) |-> (cnt >= lo) && (cnt <= hi));
endmodule

// File: rtl/cpwm_phase_out.sv
`timescale 1ns/1ps
module cpwm_phase_out #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic [CW-1:0] cnt_lead,
    input  logic [CW-1:0] cnt_trail,
    input  logic [CW-1:0] duty,
    input  logic          lvl_p,
    input  logic          lvl_n,
    output logic          out_p,
    output logic          out_n
);
    logic pos_act, neg_act;

    always_comb begin
        pos_act = (cnt_lead <= duty);
        neg_act = (cnt_trail > duty);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_p <= 1'b0;
            out_n <= 1'b0;
        end else if (run) begin
            out_p <= pos_act ? lvl_p : ~lvl_p;
            out_n <= neg_act ? lvl_n : ~lvl_n;
        end else begin
            out_p <= ~lvl_p;
            out_n <= ~lvl_n;
        end
    end

    // R6
    pair_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run |=> !((out_p == $past(lvl_p)) && (out_n == $past(lvl_n))));

    // R10
    idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (out_p == ~$past(lvl_p)) && (out_n == ~$past(lvl_n)));
endmodule

// File: rtl/cpwm3_top.sv
`timescale 1ns/1ps
module cpwm3_top
    import cpwm_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CW-1:0]     wr_data,
    output logic [NPH-1:0]    pwm_p,
    output logic [NPH-1:0]    pwm_n
);
    logic                    run;
    logic [CW-1:0]           dead_q, lim_act, cyc_act;
    logic [NOUT-1:0]         level_q;
    logic [NPH-1:0][CW-1:0]  duty_act;
    logic [CW-1:0]           cnt_lead, cnt_trail;
    logic                    trough_lead, trough_trail;

    cpwm_regs #(.CW(CW)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .trough(trough_trail), .run(run),
        .dead_q(dead_q), .level_q(level_q), .lim_act(lim_act),
        .cyc_act(cyc_act), .duty_act(duty_act)
    );

    cpwm_tri_cnt #(.CW(CW)) u_cnt_lead (
        .clk(clk), .rst_n(rst_n), .run(run), .lo(dead_q), .hi(lim_act),
        .cnt(cnt_lead), .at_trough(trough_lead)
    );

    cpwm_tri_cnt #(.CW(CW)) u_cnt_trail (
        .clk(clk), .rst_n(rst_n), .run(run), .lo('0), .hi(cyc_act),
        .cnt(cnt_trail), .at_trough(trough_trail)
    );

    for (genvar g = 0; g < NPH; g++) begin : g_phase
        cpwm_phase_out #(.CW(CW)) u_phase (
            .clk(clk), .rst_n(rst_n), .run(run),
            .cnt_lead(cnt_lead), .cnt_trail(cnt_trail), .duty(duty_act[g]),
            .lvl_p(level_q[g]), .lvl_n(level_q[NPH+g]),
            .out_p(pwm_p[g]), .out_n(pwm_n[g])
        );
    end

    // R3
    trough_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_act != '0) && (({1'b0, cyc_act} + {1'b0, dead_q}) == {1'b0, lim_act})
        |-> (trough_lead == trough_trail));
endmodule

// File: tb/cpwm3_top_tb.sv
`timescale 1ns/1ps
module cpwm3_top_tb;
    localparam int CW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [3:0]    wr_addr = '0;
    logic [CW-1:0] wr_data = '0;
    logic [2:0]    pwm_p, pwm_n;

    int errs = 0;
    int checks = 0;
    bit done = 0;

    int       m_b, m_td, m_cyc, m_cyc_b;
    bit       m_down, m_run, m_out_run;
    int       m_dbuf[3], m_dact[3];
    logic [5:0] m_lvl;
    logic [2:0] e_p, e_n;
    int       g_last[3], g_since[3];

    cpwm3_top #(.CW(CW)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .pwm_p(pwm_p), .pwm_n(pwm_n)
    );

    always #10 clk = ~clk;

    task automatic check(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic model_edge(bit we, int addr, int data);
        bit old_run = m_run;
        m_out_run = old_run;
        for (int i = 0; i < 3; i++) begin
            if (old_run) begin
                e_p[i] = (m_b + m_td <= m_dact[i]) ? m_lvl[i] : ~m_lvl[i];
                e_n[i] = (m_b > m_dact[i]) ? m_lvl[3+i] : ~m_lvl[3+i];
            end else begin
                e_p[i] = ~m_lvl[i];
                e_n[i] = ~m_lvl[3+i];
            end
        end
        if (old_run) begin
            if (m_down && m_b == 0)
                for (int i = 0; i < 3; i++) m_dact[i] = m_dbuf[i];
            if (!m_down) begin
                if (m_b >= m_cyc) begin m_b--; m_down = 1; end
                else m_b++;
            end else begin
                if (m_b == 0) begin m_b++; m_down = 0; end
                else m_b--;
            end
        end else begin
            m_b = 0; m_down = 0;
        end
        if (we) begin
            case (addr)
                0: begin
                    if ((data & 1) && !old_run) begin
                        m_run = 1; m_cyc = m_cyc_b; m_b = 0; m_down = 0;
                        for (int i = 0; i < 3; i++) m_dact[i] = m_dbuf[i];
                    end else if (!(data & 1)) begin
                        m_run = 0; m_b = 0; m_down = 0;
                    end
                end
                2: m_cyc_b = data;
                3, 4, 5: m_dbuf[addr-3] = data;
                6: if (!old_run) m_td = data;
                7: if (!old_run) m_lvl = data[5:0];
                default: ;
            endcase
        end
    endtask

    task automatic gap_track();
        for (int i = 0; i < 3; i++) begin
            if (m_out_run) begin
                bit pa = (pwm_p[i] == m_lvl[i]);
                bit na = (pwm_n[i] == m_lvl[3+i]);
                if (pa && na) check("R6", "pair overlap", 1, 0);
                if (pa) begin
                    if (g_last[i] == 2) check("R6", "gap n->p below Td", int'(g_since[i] >= m_td), 1);
                    g_last[i] = 1; g_since[i] = 0;
                end else if (na) begin
                    if (g_last[i] == 1) check("R6", "gap p->n below Td", int'(g_since[i] >= m_td), 1);
                    g_last[i] = 2; g_since[i] = 0;
                end else begin
                    g_since[i]++;
                end
            end else begin
                g_last[i] = 0; g_since[i] = 0;
            end
        end
    endtask

    task automatic step(bit we, int addr, int data, string req);
        wr_en = we; wr_addr = addr[3:0]; wr_data = data[CW-1:0];
        @(posedge clk); #1;
        model_edge(we, addr, data);
        @(negedge clk);
        wr_en = 1'b0;
        check(req, "outputs {p,n}", int'({pwm_p, pwm_n}), int'({e_p, e_n}));
        gap_track();
    endtask

    task automatic run_cycles(int n, string req);
        for (int k = 0; k < n; k++) step(0, 0, 0, req);
    endtask

    task automatic program_and_start(int cyc, int td, int d0, int d1, int d2, int lvl);
        step(1, 6, td, "R2");
        step(1, 7, lvl, "R2");
        step(1, 1, cyc + td, "R2");
        step(1, 2, cyc, "R2");
        step(1, 3, d0, "R2");
        step(1, 4, d1, "R2");
        step(1, 5, d2, "R2");
        step(1, 0, 1, "R4");
        run_cycles(2, "R4");
    endtask

    task automatic stop_run();
        step(1, 0, 0, "R10");
        run_cycles(2, "R10");
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            check("R1", "watchdog expired", 1, 0);
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        m_b = 0; m_td = 0; m_cyc = 0; m_cyc_b = 0; m_down = 0; m_run = 0; m_out_run = 0;
        m_lvl = 6'h3F;
        for (int i = 0; i < 3; i++) begin
            m_dbuf[i] = 0; m_dact[i] = 0; g_last[i] = 0; g_since[i] = 0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1", "outputs in reset", int'({pwm_p, pwm_n}), 0);
        rst_n = 1'b1;
        run_cycles(2, "R1");
        check("R1", "outputs after reset", int'({pwm_p, pwm_n}), 0);

        // directed carrier, active-high
        program_and_start(20, 3, 5, 10, 18, 6'h3F);
        run_cycles(120, "R3");

        // duty rewrites mid-run, taking effect at the trough
        step(1, 3, 15, "R7");
        run_cycles(7, "R7");
        step(1, 5, 4, "R7");
        run_cycles(45, "R7");
        step(1, 4, 19, "R7");
        run_cycles(60, "R7");

        // locked writes while running
        step(1, 6, 9, "R8");
        step(1, 7, 6'h00, "R8");
        run_cycles(50, "R8");
        stop_run();
        check("R8", "level write ignored while running", int'({pwm_p, pwm_n}), 0);

        // mixed polarity, re-run with the unchanged dead time
        step(1, 7, 6'b010110, "R9");
        run_cycles(2, "R10");
        check("R10", "idle level is inverse of polarity", int'({pwm_n, pwm_p}), int'(~6'b010110 & 6'h3F));
        step(1, 0, 1, "R4");
        run_cycles(90, "R9");
        stop_run();

        // corner cases: duty 0, duty above peak, duty below Td, zero dead time
        program_and_start(12, 0, 0, 12, 14, 6'h3F);
        run_cycles(60, "R5");
        stop_run();
        program_and_start(16, 5, 2, 0, 17, 6'b101001);
        run_cycles(70, "R5");
        stop_run();
        program_and_start(1, 0, 0, 1, 0, 6'h3F);
        run_cycles(12, "R3");
        stop_run();

        // constrained random
        for (int it = 0; it < 10; it++) begin
            int cyc = 4 + int'($urandom % 37);
            int td  = int'($urandom % (cyc / 2 + 1));
            int span = cyc + 3 - td;
            program_and_start(cyc, td, td + int'($urandom % span), td + int'($urandom % span),
                              td + int'($urandom % span), int'($urandom % 64));
            for (int k = 0; k < 6 * cyc; k++) begin
                if ($urandom % 16 == 0)
                    step(1, 3 + int'($urandom % 3), td + int'($urandom % span), "R7");
                else
                    step(0, 0, 0, "R5");
            end
            stop_run();
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule